// File: doc/BRIEF.md
# Host Transmit Word Byte Aligner

This block takes 32-bit words written by a host and feeds them, one byte per cycle, into a byte-wide packet queue. Before a buffer is sent, software writes a setup word. The setup word holds four things: a byte-order flag, a leading trim, a trailing trim and a write count. The block also samples a separately supplied packet byte size at that moment.

For each accepted data word, the block puts the four bytes into transmit order. It discards the bytes that the active trims select. The remaining bytes go out on a valid/ready byte stream.

The leading trim acts on the first word of the buffer and then clears itself. The trailing trim acts on every word written while the count is at zero, and it stays in force until the next setup write. A host write is taken only when the internal buffer has fully drained. No host data is ever dropped while the queue applies backpressure.

Top module: `tx_byte_aligner`

## Requirements
- R1: A synchronous active-high reset selects low-byte-first order, zero leading trim, zero trailing trim and a zero count. After reset, `wr_ready` is 1 and `q_valid` is 0.
- R2: When `cfg_msb_first` is 1, each word goes out starting with bits 31:24 and ending with bits 7:0. When it is 0, the word goes out starting with bits 7:0 and ending with bits 31:24.
- R3: A setup write loads the count. Each accepted data write made while the count is non-zero lowers it by one. Once the count reaches zero, it stays at zero until the next setup write.
- R4: A data write accepted while the count is non-zero discards the first `cfg_head_skip` bytes, counted in transmit order. The leading trim then clears to zero. A data write made while the count is zero never applies the leading trim.
- R5: A data write accepted while the count is zero discards the last N bytes in transmit order, where N is the trailing trim. This repeats on every such write until the next setup write.
- R6: If `pkt_size` is 1, 2 or 3 at the setup write, the trailing trim becomes 3, 2 or 1, replacing `cfg_tail_skip`. For `pkt_size` 0 or 4 and above, `cfg_tail_skip` is used.
- R7: `wr_ready` is 0 while any byte of the previous word is still pending. While `q_valid` is 1 and `q_ready` is 0, `q_data` holds its value.
- R8: In a cycle with `cfg_we` high, `wr_ready` is 0, so a data word offered in that cycle is not accepted and produces no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_msb_first | input | 1 | Byte order: 1 sends the high byte first |
| cfg_head_skip | input | 2 | Bytes dropped from the first word |
| cfg_tail_skip | input | 2 | Bytes dropped from words written at count zero |
| cfg_count | input | CNT_W | Number of writes in the buffer, minus one |
| pkt_size | input | SIZE_W | Packet byte size, sampled at the setup write |
| wr_valid | input | 1 | Host data word valid |
| wr_data | input | 32 | Host data word |
| wr_ready | output | 1 | Block can take a data word |
| q_valid | output | 1 | Byte available to the queue |
| q_data | output | 8 | Byte to the queue |
| q_ready | input | 1 | Queue accepts the byte |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- **Start and end of a multi-word buffer.** A design that applied the leading trim to more than one word would drop bytes from the middle words. One that never cleared the trim would do the same.
- **Extra writes after the count reaches zero.** A design that treated the trailing trim as one-shot would send full words there. One that let the count wrap would stop trimming.
- **Packet size at each small value and at zero.** A reversed or off-by-one mapping of the override shows up as the wrong number of bytes on the queue.
- **Order flag in both settings.** A mirrored byte order would appear on the queue.
- **Random queue backpressure.** A design that overwrote its buffer would lose bytes here.
- **Data offered in the same cycle as a setup write.** A design that accepted that data would emit stray bytes.

// File: rtl/tx_byte_aligner.sv
module tx_byte_aligner #(
  parameter int CNT_W  = 14,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_msb_first,
  input  logic [1:0]        cfg_head_skip,
  input  logic [1:0]        cfg_tail_skip,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [SIZE_W-1:0] pkt_size,
  input  logic              wr_valid,
  input  logic [31:0]       wr_data,
  output logic              wr_ready,
  output logic              q_valid,
  output logic [7:0]        q_data,
  input  logic              q_ready
);

  logic             msb_q;
  logic [1:0]       head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      sh_q;
  logic [2:0]       left_q;

  logic             accept, cnt_zero, size_small;
  logic [1:0]       hd, tl, tail_load;
  logic [31:0]      ordered;
  logic [2:0]       keep;

  assign cnt_zero   = (cnt_q == '0);
  assign accept     = wr_valid && wr_ready;
  assign wr_ready   = (left_q == 3'd0) && !cfg_we;
  assign q_valid    = (left_q != 3'd0);
  assign q_data     = sh_q[7:0];

  assign size_small = (pkt_size < SIZE_W'(4)) && (pkt_size != '0);
  assign tail_load  = size_small ? 2'(2'd0 - pkt_size[1:0]) : cfg_tail_skip;

  assign hd      = cnt_zero ? 2'd0 : head_q;
  assign tl      = cnt_zero ? tail_q : 2'd0;
  assign keep    = 3'd4 - {1'b0, hd} - {1'b0, tl};
  assign ordered = msb_q ? {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]}
                         : wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_q  <= 1'b0;
      head_q <= 2'd0;
      tail_q <= 2'd0;
      cnt_q  <= '0;
      sh_q   <= '0;
      left_q <= 3'd0;
    end else begin
      if (cfg_we) begin
        msb_q  <= cfg_msb_first;
        head_q <= cfg_head_skip;
        tail_q <= tail_load;
        cnt_q  <= cfg_count;
      end else if (accept) begin
        if (!cnt_zero) begin
          cnt_q  <= cnt_q - CNT_W'(1);
          head_q <= 2'd0;
        end
      end
      if (accept) begin
        sh_q   <= ordered >> {hd, 3'b000};
        left_q <= keep;
      end else if (q_valid && q_ready) begin
        sh_q   <= sh_q >> 8;
        left_q <= left_q - 3'd1;
      end
    end
  end

endmodule

// File: rtl/tx_byte_aligner_chk.sv
module tx_byte_aligner_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             q_valid,
  input logic [7:0]       q_data,
  input logic             q_ready,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       head_q,
  input logic [1:0]       tail_q
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!q_valid && wr_ready == !cfg_we && cnt_q == '0 && tail_q == 2'd0));

  a_r3_count_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !cfg_we) |=> cnt_q == '0);

  a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  a_r4_head_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && cnt_q != '0) |=> head_q == 2'd0);

  a_r5_tail_sticky: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(tail_q));

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> !wr_ready);

  a_r7_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_data)));

  a_r8_setup_blocks: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !wr_ready);

endmodule

bind tx_byte_aligner tx_byte_aligner_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .q_valid(q_valid), .q_data(q_data), .q_ready(q_ready),
  .cnt_q(cnt_q), .head_q(head_q), .tail_q(tail_q)
);

// File: tb/tx_byte_aligner_tb.sv
module tx_byte_aligner_tb;
  localparam int CNT_W = 14;
  localparam int SIZE_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_msb_first = 1'b0;
  logic [1:0] cfg_head_skip = '0, cfg_tail_skip = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [SIZE_W-1:0] pkt_size = '0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready, q_valid, q_ready = 1'b1;
  logic [7:0] q_data;

  int checks = 0, errors = 0, cycles = 0;
  bit rand_ready = 0, done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  int m_msb = 0, m_head = 0, m_tail = 0, m_cnt = 0;

  always #4 clk = ~clk;

  tx_byte_aligner #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_msb_first(cfg_msb_first),
    .cfg_head_skip(cfg_head_skip), .cfg_tail_skip(cfg_tail_skip), .cfg_count(cfg_count),
    .pkt_size(pkt_size), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .q_valid(q_valid), .q_data(q_data), .q_ready(q_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      q_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_valid && q_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7/R8 unexpected byte", q_data, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(q_data == e, t, q_data, e);
        end
      end
    end
  end

  task automatic setup(input int msb, input int head, input int tail, input int cnt,
                       input int size, input bit with_data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_msb_first = msb[0]; cfg_head_skip = head[1:0];
    cfg_tail_skip = tail[1:0]; cfg_count = CNT_W'(cnt); pkt_size = SIZE_W'(size);
    if (with_data) begin wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF; end
    m_msb = msb; m_head = head; m_cnt = cnt;
    m_tail = (size >= 1 && size <= 3) ? 4 - size : tail;
    @(negedge clk);
    cfg_we = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input string tag);
    int hd, tl;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    hd = (m_cnt != 0) ? m_head : 0;
    tl = (m_cnt == 0) ? m_tail : 0;
    if (m_cnt != 0) begin m_cnt--; m_head = 0; end
    for (int i = 0; i < 4; i++) begin
      if (i >= hd && i < 4 - tl) begin
        exp_q.push_back(m_msb != 0 ? d[8*(3-i) +: 8] : d[8*i +: 8]);
        tag_q.push_back(tag);
      end
    end
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (q_valid || exp_q.size() != 0) @(negedge clk);
    #1;
    check(exp_q.size() == 0 && wr_ready, "R7 drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    check(q_valid == 1'b0, "R1 q_valid after reset", q_valid, 0);

    send(32'h4433_2211, "R1/R2 lsb-first default");
    drain();

    // R2 R3 R4 R5: head 1, tail 2, three-word buffer plus extra writes
    setup(1, 1, 2, 2, 100, 0);
    send(32'hA1A2_A3A4, "R4 head trim msb");
    send(32'hB1B2_B3B4, "R3 middle word full");
    send(32'hC1C2_C3C4, "R5 tail trim msb");
    send(32'hD1D2_D3D4, "R5 tail sticky");
    send(32'hE1E2_E3E4, "R5 tail sticky again");
    drain();

    // R4: head not applied at count zero
    setup(0, 2, 1, 0, 0, 0);
    send(32'h1122_3344, "R4 no head at count zero");
    drain();

    // R3 count one, little-endian
    setup(0, 3, 3, 1, 8, 0);
    send(32'h5566_7788, "R4 head trim lsb");
    send(32'h99AA_BBCC, "R3 R5 tail at count zero lsb");
    drain();

    // R6 size override for each small value
    for (int s = 0; s < 4; s++) begin
      setup(s % 2, 0, 1, 0, s, 0);
      send(32'hF0E1_D2C3 + s, "R6 size override");
      send(32'h0102_0304 + s, "R6 override sticky");
      drain();
    end

    // R8 data offered during setup write is not taken
    setup(1, 0, 0, 0, 0, 1);
    @(negedge clk); #1;
    check(q_valid == 1'b0, "R8 no bytes from collided write", q_valid, 0);
    send(32'h7766_5544, "R8 next word after setup");
    drain();

    // R7 backpressure on a long buffer
    rand_ready = 1;
    setup(1, 2, 3, 5, 50, 0);
    for (int i = 0; i < 8; i++) send(32'h1000_0000 * i + 32'h0A0B_0C0D, "R7 backpressure");
    drain();
    rand_ready = 0;
    @(negedge clk);
    setup(0, 1, 0, 3, 4, 0);
    rand_ready = 1;
    for (int i = 0; i < 5; i++) send(32'hCAFE_0000 + i, "R7 backpressure lsb");
    drain();
    rand_ready = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule